// File: doc/BRIEF.md
# Slot-Select Serial Writer

This block sits on the host side of a three-wire bit-serial link and sends one slot-select word to a module chassis. The link carries an active-low framing strobe, a serial clock and a serial data line. When a requester pulses the start input while the block is idle, the word on the input is captured. The strobe is pulled low and held there for a lead-in interval. The word then leaves most-significant bit first. For each bit the data line takes its new value, the clock is held low, and then the clock is raised; the receiver captures the bit on that rising edge. After the last bit the strobe is released, which commits the selection. A one-cycle done pulse marks that moment.

Every phase is stretched to meet fixed nanosecond minimums: clock-low time, clock-high time, data setup before the rising edge, and data hold after it. The minimums and the system-clock period are parameters. The block rounds each quotient up to whole cycles at elaboration. To leave no module selected when no traffic is pending, the requester sends an all-zero word, which the block shifts like any other.

Top module: `slotsel_tx`

## Requirements
- R1: During and directly after reset, the strobe `sel_n_o` and the clock `sclk_o` are 1, and `busy_o` and `done_o` are 0. A reset in the middle of a transfer returns the block to this state.
- R2: A start pulse while idle drives `sel_n_o` low and `busy_o` high from the next cycle. The clock stays high for at least ceil(SETUP_NS/CLK_NS) cycles before its first falling edge.
- R3: During one strobe-low interval exactly WORD_W rising clock edges occur. The bits sampled on them, first to last, equal the captured word from bit WORD_W-1 down to bit 0.
- R4: Every clock-low phase lasts at least ceil(LOW_NS/CLK_NS) cycles. Every clock-high phase between two bits lasts at least ceil(HIGH_NS/CLK_NS) cycles.
- R5: The data line is stable for at least ceil(SETUP_NS/CLK_NS) cycles before each rising edge. It stays unchanged for at least ceil(HOLD_NS/CLK_NS) cycles after each rising edge and never changes while the clock is high inside a frame.
- R6: The strobe returns high with the clock high. The return comes at least max(ceil(HIGH_NS/CLK_NS), ceil(HOLD_NS/CLK_NS)) cycles after the last rising edge.
- R7: `done_o` is a one-cycle pulse. It is high exactly in the cycle in which `sel_n_o` returns high, and `busy_o` is 0 in that cycle.
- R8: A start pulse during a transfer is ignored. The word being sent is unchanged, and no second frame follows.
- R9: The clock never goes low while the strobe is high.
- R10: An all-zero word holds the data line at 0 for the entire strobe-low interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| word_i | input | WORD_W | Slot-select word captured with the start request |
| busy_o | output | 1 | High from frame start until the strobe is released |
| done_o | output | 1 | One-cycle pulse when the selection is committed |
| sel_n_o | output | 1 | Active-low framing strobe |
| sclk_o | output | 1 | Serial clock, rests high |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The checker watches several rules on every cycle. It confirms that no clock edge appears outside a frame and that a frame starts only after a start request. It checks that data never moves while the clock is high inside a frame and that every low phase meets its minimum cycle count. It also checks that the done pulse lasts one cycle and coincides exactly with the strobe release. Only the bench scenarios can show that the bits sampled on the rising edges spell out the captured word in MSB-first order and that the setup, hold, lead-in and tail intervals reach their rounded-up minimums. The same applies to a start issued mid-frame being ignored, an all-zero word keeping the data line low, and a mid-frame reset.

// File: rtl/slotsel_pkg.sv
package slotsel_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_FRAME = 2'd1,
      PH_LOW   = 2'd2,
      PH_HIGH  = 2'd3
   } phase_e;

   // whole system-clock cycles covering a duration, rounded up
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/slotsel_timer.sv
module slotsel_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/slotsel_shifter.sv
module slotsel_shifter #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   input  logic              shift,
   output logic              msb_o,
   output logic              last_o
);

   localparam int unsigned IDX_W = $clog2(WORD_W);

   logic [WORD_W-1:0] sreg_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         sreg_q <= word;
         idx_q  <= '0;
      end else if (shift) begin
         sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
         idx_q  <= idx_q + 1'b1;
      end
   end

   assign msb_o  = sreg_q[WORD_W-1];
   assign last_o = (idx_q == IDX_W'(WORD_W - 1));

endmodule

// File: rtl/slotsel_fsm.sv
module slotsel_fsm
   import slotsel_pkg::*;
#(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned FRAME_N = 20,
   parameter int unsigned LOW_N   = 20,
   parameter int unsigned HIGH_N  = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             expired,
   input  logic             last,
   output phase_e           phase,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             sh_load,
   output logic             sh_shift,
   output logic             done_o
);

   phase_e phase_q, phase_d;
   logic   done_q, done_d;

   always_comb begin
      phase_d  = phase_q;
      done_d   = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      unique case (phase_q)
         PH_IDLE: if (start) begin
            phase_d  = PH_FRAME;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(FRAME_N - 1);
            sh_load  = 1'b1;
         end
         PH_FRAME: if (expired) begin
            phase_d  = PH_LOW;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(LOW_N - 1);
         end
         PH_LOW: if (expired) begin
            phase_d  = PH_HIGH;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HIGH_N - 1);
         end
         PH_HIGH: if (expired) begin
            if (last) begin
               phase_d = PH_IDLE;
               done_d  = 1'b1;
            end else begin
               phase_d  = PH_LOW;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(LOW_N - 1);
               sh_shift = 1'b1;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= done_d;
      end
   end

   assign phase  = phase_q;
   assign done_o = done_q;

endmodule

// File: rtl/slotsel_tx.sv
module slotsel_tx
   import slotsel_pkg::*;
#(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned CLK_NS   = 10,
   parameter int unsigned LOW_NS   = 65,
   parameter int unsigned HIGH_NS  = 400,
   parameter int unsigned SETUP_NS = 200,
   parameter int unsigned HOLD_NS  = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              sel_n_o,
   output logic              sclk_o,
   output logic              sdata_o
);

   localparam int unsigned LOW_CYC   = ns_to_cyc(LOW_NS, CLK_NS);
   localparam int unsigned HIGH_CYC  = ns_to_cyc(HIGH_NS, CLK_NS);
   localparam int unsigned SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_NS);
   localparam int unsigned HOLD_CYC  = ns_to_cyc(HOLD_NS, CLK_NS);
   // data changes with the falling clock edge, so the low phase carries setup
   localparam int unsigned LOW_N     = max2(max2(LOW_CYC, SETUP_CYC), 1);
   localparam int unsigned HIGH_N    = max2(max2(HIGH_CYC, HOLD_CYC), 1);
   localparam int unsigned FRAME_N   = max2(SETUP_CYC, 1);
   localparam int unsigned LONGEST   = max2(max2(LOW_N, HIGH_N), FRAME_N);
   localparam int unsigned CNT_W     = $clog2(LONGEST + 1);

   generate
      if (WORD_W < 2)
         $error("slotsel_tx: WORD_W must be at least 2");
      if (CLK_NS < 1)
         $error("slotsel_tx: CLK_NS must be at least 1");
   endgenerate

   phase_e           phase;
   logic             tmr_load, tmr_expired, sh_load, sh_shift, sh_msb, sh_last;
   logic [CNT_W-1:0] tmr_val;

   slotsel_fsm #(
      .CNT_W  (CNT_W),
      .FRAME_N(FRAME_N),
      .LOW_N  (LOW_N),
      .HIGH_N (HIGH_N)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_i),
      .expired (tmr_expired),
      .last    (sh_last),
      .phase   (phase),
      .tmr_load(tmr_load),
      .tmr_val (tmr_val),
      .sh_load (sh_load),
      .sh_shift(sh_shift),
      .done_o  (done_o)
   );

   slotsel_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .expired (tmr_expired)
   );

   slotsel_shifter #(.WORD_W(WORD_W)) u_sh (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sh_load),
      .word  (word_i),
      .shift (sh_shift),
      .msb_o (sh_msb),
      .last_o(sh_last)
   );

   assign busy_o  = (phase != PH_IDLE);
   assign sel_n_o = (phase == PH_IDLE);
   assign sclk_o  = (phase != PH_LOW);
   assign sdata_o = (phase == PH_IDLE) ? 1'b0 : sh_msb;

endmodule

// File: rtl/slotsel_chk.sv
module slotsel_chk #(
   parameter int unsigned LOW_CYC = 1
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic sel_n_o,
   input logic sclk_o,
   input logic sdata_o
);

   logic [15:0] low_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_run_q <= '0;
      else if (sclk_o)
         low_run_q <= '0;
      else if (low_run_q != 16'hFFFF)
         low_run_q <= low_run_q + 1'b1;
   end

   AST_NO_CLK_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_o |-> sclk_o); // R9

   AST_FRAME_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sel_n_o) |-> $past(start_i)); // R2

   AST_LOW_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> (low_run_q >= 16'(LOW_CYC))); // R4

   AST_DATA_STILL_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sclk_o) && !sel_n_o) |-> $stable(sdata_o)); // R5

   AST_DATA_STILL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n_o && $past(!sel_n_o) && sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R5

   AST_RELEASE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n_o) |-> (sclk_o && $past(sclk_o))); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sel_n_o) |-> (done_o && !busy_o)); // R7

   AST_DONE_ONLY_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $rose(sel_n_o)); // R7

endmodule

bind slotsel_tx slotsel_chk #(.LOW_CYC(LOW_CYC)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .busy_o (busy_o),
   .done_o (done_o),
   .sel_n_o(sel_n_o),
   .sclk_o (sclk_o),
   .sdata_o(sdata_o)
);

// File: tb/sim_slotsel_tx.sv
module sim_slotsel_tx;

   localparam int PERIOD   = 10;
   localparam int W        = 16;
   localparam int LOW_MIN  = (65 + PERIOD - 1) / PERIOD;
   localparam int HIGH_MIN = (400 + PERIOD - 1) / PERIOD;
   localparam int SET_MIN  = (200 + PERIOD - 1) / PERIOD;
   localparam int HOLD_MIN = (200 + PERIOD - 1) / PERIOD;
   localparam int TAIL_MIN = (HIGH_MIN > HOLD_MIN) ? HIGH_MIN : HOLD_MIN;
   localparam int WD_LIMIT = 5000;
   localparam int NVEC     = 6;
   localparam logic [W-1:0] VEC [NVEC] = '{16'hA5C3, 16'h0000, 16'hFFFF,
                                           16'h8000, 16'h0001, 16'h3C5A};

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
   logic [W-1:0] word_i = '0;
   logic busy_o, done_o, sel_n_o, sclk_o, sdata_o;

   int checks = 0, fails = 0;

   slotsel_tx #(.WORD_W(W), .CLK_NS(PERIOD)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i),
      .busy_o(busy_o), .done_o(done_o), .sel_n_o(sel_n_o),
      .sclk_o(sclk_o), .sdata_o(sdata_o)
   );

   always #(PERIOD/2) clk = ~clk;

   // observation of the link, sampled on the falling system-clock edge
   logic p_sel = 1'b1, p_clk = 1'b1, p_dat = 1'b0;
   logic [W-1:0] cap;
   logic any_one, fell_seen, done_rel, busy_rel;
   int nbits, lead, low_run, high_run, stable_run, tail;
   int min_low, min_high, min_setup, min_hold;
   int frames = 0, dones = 0, idle_clk_bad = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_sel = 1'b1; p_clk = 1'b1; p_dat = 1'b0;
      end else begin
         if (sel_n_o && !sclk_o) idle_clk_bad++;
         if (p_sel && !sel_n_o) begin
            cap = '0; nbits = 0; lead = 1; fell_seen = 1'b0;
            min_low = 99999; min_high = 99999; min_setup = 99999; min_hold = 99999;
            low_run = 0; high_run = 1; stable_run = 1; any_one = sdata_o;
         end else if (!sel_n_o) begin
            if (sdata_o) any_one = 1'b1;
            stable_run = (sdata_o != p_dat) ? 1 : stable_run + 1;
            if (!fell_seen && sclk_o) lead++;
            if (p_clk && !sclk_o) begin
               fell_seen = 1'b1;
               if (nbits > 0 && high_run < min_high) min_high = high_run;
               if (nbits > 0 && high_run < min_hold) min_hold = high_run;
               low_run = 1;
            end else if (!p_clk && sclk_o) begin
               nbits++;
               cap = {cap[W-2:0], sdata_o};
               if (low_run < min_low) min_low = low_run;
               if (stable_run - 1 < min_setup) min_setup = stable_run - 1;
               high_run = 1;
            end else if (sclk_o) high_run++;
            else low_run++;
         end
         if (!p_sel && sel_n_o) begin
            tail = high_run; done_rel = done_o; busy_rel = busy_o; frames++;
         end
         if (done_o) dones++;
         p_sel = sel_n_o; p_clk = sclk_o; p_dat = sdata_o;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic send(input logic [W-1:0] w, input bit poke);
      int f0 = frames;
      int wd = 0;
      @(negedge clk); word_i = w; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0; word_i = ~w;
      chk(busy_o === 1'b1 && sel_n_o === 1'b0, "R2 busy and strobe after start",
          {busy_o, sel_n_o}, 2'b10);
      if (poke) begin
         repeat (100) @(negedge clk);
         word_i = 16'h1234; start_i = 1'b1;
         @(negedge clk); start_i = 1'b0;
      end
      while (frames == f0 && wd < WD_LIMIT) begin
         @(negedge clk); wd++;
      end
      chk(wd < WD_LIMIT, "R7 transfer completes", wd, WD_LIMIT);
   endtask

   task automatic check_frame(input logic [W-1:0] w);
      chk(nbits == W, "R3 rising edge count", nbits, W);
      chk(cap == w, "R3 word sampled MSB first", cap, w);
      chk(lead >= SET_MIN, "R2 strobe lead before first clock", lead, SET_MIN);
      chk(min_low >= LOW_MIN, "R4 clock low phase", min_low, LOW_MIN);
      chk(min_high >= HIGH_MIN, "R4 clock high phase", min_high, HIGH_MIN);
      chk(min_setup >= SET_MIN, "R5 data setup", min_setup, SET_MIN);
      chk(min_hold >= HOLD_MIN, "R5 data hold", min_hold, HOLD_MIN);
      chk(tail >= TAIL_MIN, "R6 release after last bit", tail, TAIL_MIN);
      chk(done_rel === 1'b1 && busy_rel === 1'b0, "R7 done with release",
          {done_rel, busy_rel}, 2'b10);
   endtask

   initial begin
      #(PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int d0;
      repeat (3) @(negedge clk);
      chk(sel_n_o === 1'b1 && sclk_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0,
          "R1 state in reset", {sel_n_o, sclk_o, busy_o, done_o}, 4'b1100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sel_n_o === 1'b1 && sclk_o === 1'b1 && busy_o === 1'b0,
          "R1 idle after reset", {sel_n_o, sclk_o, busy_o}, 3'b110);

      // table of words walked by one loop
      for (int i = 0; i < NVEC; i++) begin
         d0 = dones;
         send(VEC[i], 1'b0);
         check_frame(VEC[i]);
         @(negedge clk);
         chk(dones - d0 == 1, "R7 single done pulse", dones - d0, 1);
         if (VEC[i] == '0)
            chk(any_one == 1'b0, "R10 zero word keeps data low", any_one, 0);
      end

      // start issued mid-frame is ignored
      d0 = frames;
      send(16'hC0DE, 1'b1);
      check_frame(16'hC0DE);
      repeat (200) @(negedge clk);
      chk(frames - d0 == 1 && sel_n_o === 1'b1, "R8 no second frame",
          frames - d0, 1);

      chk(idle_clk_bad == 0, "R9 no clock outside frame", idle_clk_bad, 0);

      // reset in the middle of a transfer
      @(negedge clk); word_i = 16'hFFFF; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (150) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(sel_n_o === 1'b1 && sclk_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0,
          "R1 mid-frame reset", {sel_n_o, sclk_o, busy_o, done_o}, 4'b1100);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(sel_n_o === 1'b1 && busy_o === 1'b0, "R1 stays idle after reset",
          {sel_n_o, busy_o}, 2'b10);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule